// File: doc/BRIEF.md
# I2C Transfer Byte Buffer

This block sits between a host register port and an I2C byte engine and holds two byte queues: one carrying bytes the host writes toward the bus, one carrying bytes the engine has received for the host. Each queue has its own threshold, set from a configuration register. The block tells the host when a full burst of threshold size can be moved.

When a transfer ends with a burst smaller than the threshold, a separate drain indication marks it. The host then reads the exact fill level from the status register and moves only that many bytes. Each access to the data address moves exactly one byte.

Error pulses flag a host read of an empty receive queue, an engine byte dropped because the receive queue is full, and an engine request for a byte the transmit queue does not hold. The total depth is fixed at build time as 8 shifted left by a 2-bit code, and the status register reports that code.

Top module: `i2c_xfer_buffer`

## Requirements
- R1: After reset both queues are empty, the configuration register reads 0, the status register reads the depth code in bits 15:14 with zero levels, and no event or error output is high while the remaining count is 0.
- R2: The configuration register (address 1) holds the transmit threshold minus one in its low bits, the receive threshold minus one from bit 8, the transmit DMA enable at bit 7 and the receive DMA enable at bit 15; bits 6 and 14 always read back as 0.
- R3: Writing the configuration register with bit 6 set empties the transmit queue, and with bit 14 set empties the receive queue, both in the cycle of the write, without touching the other queue.
- R4: The status register (address 2) reports the depth code in bits 15:14, the transmit fill level in bits 6:0 and the receive fill level in bits 13:7; a level never exceeds the depth 8<<code.
- R5: Both queues deliver bytes in the order they entered, one byte per data-address access (address 0) or per engine strobe, across pointer wrap-around.
- R6: rx_ready is high whenever the receive level is at least the receive threshold.
- R7: tx_ready is high when the free transmit space is at least the transmit threshold and the bytes the host still owes (remaining count minus transmit level) are at least the threshold.
- R8: rx_drain is high when the remaining count is 0 and the receive level is nonzero but below the threshold; it is never high together with rx_ready.
- R9: tx_drain is high when the bytes the host still owes are nonzero, below the transmit threshold, and fit in the free space; it is never high together with tx_ready.
- R10: A host read of an empty receive queue returns 0 and an engine push into a full receive queue is dropped; either raises rx_overrun for the one following cycle.
- R11: An engine byte request on an empty transmit queue returns 0 on eng_tx_data and raises tx_underflow for the one following cycle.
- R12: A host data write into a full transmit queue is dropped and leaves the level and contents unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (pops on data address) |
| reg_addr | input | 2 | 0 data, 1 configuration, 2 status |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Read data, valid in the cycle of the read |
| eng_tx_req | input | 1 | Engine takes one transmit byte |
| eng_tx_data | output | 8 | Head of transmit queue (0 when empty) |
| eng_rx_push | input | 1 | Engine delivers one received byte |
| eng_rx_data | input | 8 | Received byte |
| eng_rem | input | REM_W | Bytes of the current transfer still to be moved by the engine |
| tx_ready | output | 1 | Transmit burst of threshold size may be written |
| rx_ready | output | 1 | Receive burst of threshold size may be read |
| tx_drain | output | 1 | Final short transmit burst pending |
| rx_drain | output | 1 | Final short receive burst pending |
| rx_overrun | output | 1 | One-cycle receive overrun pulse |
| tx_underflow | output | 1 | One-cycle transmit underflow pulse |

## Verification
A corrupted pointer or level shows at the ports at once: the status level read after the access differs from the count of accepted bytes, and the next byte popped breaks the scoreboard order. A wrong full or empty decision appears one cycle after the offending access as a missing or spurious error pulse, and as a level that moved when it should have held. Threshold or drain logic errors appear combinationally on the event outputs as soon as the level or remaining count crosses a boundary, so the bench samples them right after each single byte move.

// File: rtl/i2c_buf_pkg.sv
package i2c_buf_pkg;
   localparam logic [1:0] RA_DATA = 2'd0;
   localparam logic [1:0] RA_CFG  = 2'd1;
   localparam logic [1:0] RA_STAT = 2'd2;

   localparam int TX_CLR_BIT = 6;
   localparam int TX_DMA_BIT = 7;
   localparam int RX_THR_LSB = 8;
   localparam int RX_CLR_BIT = 14;
   localparam int RX_DMA_BIT = 15;
   localparam int CODE_LSB   = 14;
   localparam int LVL_W      = 7;
   localparam int RX_LVL_LSB = 7;
endpackage

// File: rtl/i2c_buf_fifo.sv
module i2c_buf_fifo #(
   parameter int DW    = 8,
   parameter int DEPTH = 16,
   localparam int AW   = $clog2(DEPTH),
   localparam int LW   = AW + 1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          flush,
   input  logic          push,
   input  logic [DW-1:0] wdata,
   input  logic          pop,
   output logic [DW-1:0] rdata,
   output logic [LW-1:0] level,
   output logic          full,
   output logic          empty,
   output logic          push_drop,
   output logic          pop_empty
);
   logic [DW-1:0] mem [DEPTH];
   logic [AW-1:0] wptr, rptr;
   logic [LW-1:0] cnt;
   logic          push_ok, pop_ok;

   if ((1 << AW) != DEPTH) begin : g_bad_depth
      $error("i2c_buf_fifo: DEPTH must be a power of two");
   end

   assign full      = (cnt == LW'(DEPTH));
   assign empty     = (cnt == '0);
   assign push_ok   = push & ~full & ~flush;
   assign pop_ok    = pop & ~empty;
   assign push_drop = push & full & ~flush;
   assign pop_empty = pop & empty;
   assign rdata     = empty ? '0 : mem[rptr];
   assign level     = cnt;

   always_ff @(posedge clk) begin
      if (push_ok) mem[wptr] <= wdata;
   end

   always_ff @(posedge clk) begin
      if (!rst_n || flush) begin
         wptr <= '0;
         rptr <= '0;
         cnt  <= '0;
      end else begin
         if (push_ok) wptr <= wptr + 1'b1;
         if (pop_ok)  rptr <= rptr + 1'b1;
         case ({push_ok, pop_ok})
            2'b10:   cnt <= cnt + 1'b1;
            2'b01:   cnt <= cnt - 1'b1;
            default: cnt <= cnt;
         endcase
      end
   end
endmodule

// File: rtl/i2c_buf_events.sv
module i2c_buf_events #(
   parameter int DEPTH = 16,
   parameter int REM_W = 16,
   localparam int LW   = $clog2(DEPTH) + 1
) (
   input  logic [LW-1:0]    tx_level,
   input  logic [LW-1:0]    rx_level,
   input  logic [LW-1:0]    tx_thr,
   input  logic [LW-1:0]    rx_thr,
   input  logic [REM_W-1:0] eng_rem,
   output logic             tx_ready,
   output logic             tx_drain,
   output logic             rx_ready,
   output logic             rx_drain
);
   logic [REM_W-1:0] tx_lvl_x, tx_thr_x, tx_free_x, tx_need;

   if (REM_W < LW) begin : g_bad_rem
      $error("i2c_buf_events: REM_W too narrow for the level");
   end

   assign tx_lvl_x  = REM_W'(tx_level);
   assign tx_thr_x  = REM_W'(tx_thr);
   assign tx_free_x = REM_W'(LW'(DEPTH) - tx_level);
   assign tx_need   = (eng_rem > tx_lvl_x) ? (eng_rem - tx_lvl_x) : '0;

   assign tx_ready = (tx_free_x >= tx_thr_x) && (tx_need >= tx_thr_x);
   assign tx_drain = (tx_need != '0) && (tx_need < tx_thr_x) && (tx_free_x >= tx_need);
   assign rx_ready = (rx_level >= rx_thr);
   assign rx_drain = (eng_rem == '0) && (rx_level != '0) && (rx_level < rx_thr);
endmodule

// File: rtl/i2c_xfer_buffer.sv
module i2c_xfer_buffer #(
   parameter int DEPTH_CODE = 1,
   parameter int REM_W      = 16,
   localparam int DEPTH     = 8 << DEPTH_CODE,
   localparam int AW        = $clog2(DEPTH),
   localparam int LW        = AW + 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             reg_wr,
   input  logic             reg_rd,
   input  logic [1:0]       reg_addr,
   input  logic [15:0]      reg_wdata,
   output logic [15:0]      reg_rdata,
   input  logic             eng_tx_req,
   output logic [7:0]       eng_tx_data,
   input  logic             eng_rx_push,
   input  logic [7:0]       eng_rx_data,
   input  logic [REM_W-1:0] eng_rem,
   output logic             tx_ready,
   output logic             rx_ready,
   output logic             tx_drain,
   output logic             rx_drain,
   output logic             rx_overrun,
   output logic             tx_underflow
);
   import i2c_buf_pkg::*;

   if (DEPTH_CODE < 0 || DEPTH_CODE > 3) begin : g_bad_code
      $error("i2c_xfer_buffer: DEPTH_CODE must be 0..3");
   end

   logic [AW-1:0] tx_thr_m1, rx_thr_m1;
   logic          dma_tx_en, dma_rx_en;
   logic          cfg_wr, data_wr, data_rd, tx_flush, rx_flush;
   logic [LW-1:0] tx_level, rx_level;
   logic [7:0]    rx_head;
   logic          tx_full, tx_empty, rx_full, rx_empty;
   logic          tx_drop, tx_pop_empty, rx_drop, rx_pop_empty;
   logic [15:0]   cfg_img, stat_img;

   assign cfg_wr   = reg_wr && (reg_addr == RA_CFG);
   assign data_wr  = reg_wr && (reg_addr == RA_DATA);
   assign data_rd  = reg_rd && (reg_addr == RA_DATA);
   assign tx_flush = cfg_wr && reg_wdata[TX_CLR_BIT];
   assign rx_flush = cfg_wr && reg_wdata[RX_CLR_BIT];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         tx_thr_m1 <= '0;
         rx_thr_m1 <= '0;
         dma_tx_en <= 1'b0;
         dma_rx_en <= 1'b0;
      end else if (cfg_wr) begin
         tx_thr_m1 <= reg_wdata[AW-1:0];
         rx_thr_m1 <= reg_wdata[RX_THR_LSB +: AW];
         dma_tx_en <= reg_wdata[TX_DMA_BIT];
         dma_rx_en <= reg_wdata[RX_DMA_BIT];
      end
   end

   i2c_buf_fifo #(.DW(8), .DEPTH(DEPTH)) u_txq (
      .clk(clk), .rst_n(rst_n), .flush(tx_flush),
      .push(data_wr), .wdata(reg_wdata[7:0]),
      .pop(eng_tx_req), .rdata(eng_tx_data),
      .level(tx_level), .full(tx_full), .empty(tx_empty),
      .push_drop(tx_drop), .pop_empty(tx_pop_empty)
   );

   i2c_buf_fifo #(.DW(8), .DEPTH(DEPTH)) u_rxq (
      .clk(clk), .rst_n(rst_n), .flush(rx_flush),
      .push(eng_rx_push), .wdata(eng_rx_data),
      .pop(data_rd), .rdata(rx_head),
      .level(rx_level), .full(rx_full), .empty(rx_empty),
      .push_drop(rx_drop), .pop_empty(rx_pop_empty)
   );

   i2c_buf_events #(.DEPTH(DEPTH), .REM_W(REM_W)) u_evt (
      .tx_level(tx_level), .rx_level(rx_level),
      .tx_thr(LW'(tx_thr_m1) + 1'b1), .rx_thr(LW'(rx_thr_m1) + 1'b1),
      .eng_rem(eng_rem),
      .tx_ready(tx_ready), .tx_drain(tx_drain),
      .rx_ready(rx_ready), .rx_drain(rx_drain)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rx_overrun   <= 1'b0;
         tx_underflow <= 1'b0;
      end else begin
         rx_overrun   <= rx_drop | rx_pop_empty;
         tx_underflow <= tx_pop_empty;
      end
   end

   always_comb begin
      cfg_img = '0;
      cfg_img[AW-1:0]            = tx_thr_m1;
      cfg_img[RX_THR_LSB +: AW]  = rx_thr_m1;
      cfg_img[TX_DMA_BIT]        = dma_tx_en;
      cfg_img[RX_DMA_BIT]        = dma_rx_en;
      stat_img = '0;
      stat_img[CODE_LSB +: 2]    = 2'(DEPTH_CODE);
      stat_img[0 +: LVL_W]       = LVL_W'(tx_level);
      stat_img[RX_LVL_LSB +: LVL_W] = LVL_W'(rx_level);
      case (reg_addr)
         RA_DATA: reg_rdata = {8'h00, rx_head};
         RA_CFG:  reg_rdata = cfg_img;
         RA_STAT: reg_rdata = stat_img;
         default: reg_rdata = '0;
      endcase
   end

   logic unused_sink;
   assign unused_sink = ^{reg_wdata, tx_full, tx_empty, rx_full, rx_empty, tx_drop};
endmodule

// File: rtl/i2c_buf_chk.sv
module i2c_buf_chk #(
   parameter int DEPTH = 16,
   localparam int LW   = $clog2(DEPTH) + 1
) (
   input logic          clk,
   input logic          rst_n,
   input logic          reg_wr,
   input logic          reg_rd,
   input logic [1:0]    reg_addr,
   input logic [15:0]   reg_wdata,
   input logic          eng_tx_req,
   input logic          eng_rx_push,
   input logic [LW-1:0] tx_level,
   input logic [LW-1:0] rx_level,
   input logic          tx_ready,
   input logic          tx_drain,
   input logic          rx_ready,
   input logic          rx_drain,
   input logic          rx_overrun,
   input logic          tx_underflow
);
   p_tx_flush_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_wr && reg_addr == 2'd1 && reg_wdata[6]) |=> (tx_level == '0));

   p_rx_flush_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_wr && reg_addr == 2'd1 && reg_wdata[14]) |=> (rx_level == '0));

   p_level_bound_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (tx_level <= LW'(DEPTH)) && (rx_level <= LW'(DEPTH)));

   p_rx_pop_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_rd && reg_addr == 2'd0 && rx_level != '0 && !eng_rx_push)
      |=> (rx_level == $past(rx_level) - 1'b1));

   p_rx_excl_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !(rx_ready && rx_drain));

   p_tx_excl_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !(tx_ready && tx_drain));

   p_rx_overrun_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (eng_rx_push && rx_level == LW'(DEPTH) &&
       !(reg_wr && reg_addr == 2'd1 && reg_wdata[14])) |=> rx_overrun);

   p_tx_underflow_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (eng_tx_req && tx_level == '0) |=> tx_underflow);

   p_tx_full_drop_r12: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_wr && reg_addr == 2'd0 && tx_level == LW'(DEPTH) && !eng_tx_req)
      |=> (tx_level == LW'(DEPTH)));
endmodule

bind i2c_xfer_buffer i2c_buf_chk #(.DEPTH(DEPTH)) u_chk (
   .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
   .reg_addr(reg_addr), .reg_wdata(reg_wdata),
   .eng_tx_req(eng_tx_req), .eng_rx_push(eng_rx_push),
   .tx_level(tx_level), .rx_level(rx_level),
   .tx_ready(tx_ready), .tx_drain(tx_drain),
   .rx_ready(rx_ready), .rx_drain(rx_drain),
   .rx_overrun(rx_overrun), .tx_underflow(tx_underflow)
);

// File: tb/sim_i2c_xfer_buffer.sv
module sim_i2c_xfer_buffer;
   localparam int CODE  = 1;
   localparam int DEPTH = 8 << CODE;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        reg_wr = 1'b0, reg_rd = 1'b0;
   logic [1:0]  reg_addr = 2'd0;
   logic [15:0] reg_wdata = '0;
   logic [15:0] reg_rdata;
   logic        eng_tx_req = 1'b0, eng_rx_push = 1'b0;
   logic [7:0]  eng_tx_data, eng_rx_data = '0;
   logic [15:0] eng_rem = '0;
   logic        tx_ready, rx_ready, tx_drain, rx_drain, rx_overrun, tx_underflow;

   int total = 0, bad = 0;
   bit done = 1'b0;
   logic [7:0] txq[$];
   logic [7:0] rxq[$];
   int tx_cnt = 0, rx_cnt = 0;

   always #10 clk = ~clk;

   i2c_xfer_buffer #(.DEPTH_CODE(CODE), .REM_W(16)) u0 (
      .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
      .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
      .eng_tx_req(eng_tx_req), .eng_tx_data(eng_tx_data),
      .eng_rx_push(eng_rx_push), .eng_rx_data(eng_rx_data), .eng_rem(eng_rem),
      .tx_ready(tx_ready), .rx_ready(rx_ready), .tx_drain(tx_drain),
      .rx_drain(rx_drain), .rx_overrun(rx_overrun), .tx_underflow(tx_underflow)
   );

   task automatic check(input bit ok, input string req, input int act, input int exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
      end
   endtask

   task automatic host_write(input logic [1:0] a, input logic [15:0] d);
      @(negedge clk);
      reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
      @(negedge clk);
      reg_wr = 1'b0; reg_wdata = '0;
   endtask

   task automatic host_read(input logic [1:0] a, output logic [15:0] d);
      @(negedge clk);
      reg_rd = 1'b1; reg_addr = a;
      #1 d = reg_rdata;
      @(negedge clk);
      reg_rd = 1'b0;
   endtask

   // driver: host byte into transmit queue, expected item recorded
   task automatic tx_write(input logic [7:0] b);
      host_write(2'd0, {8'h00, b});
      if (tx_cnt < DEPTH) begin txq.push_back(b); tx_cnt++; end
   endtask

   // monitor: engine takes a byte, compared against the scoreboard
   task automatic eng_pull(input string req);
      logic [7:0] got, exp;
      @(negedge clk);
      eng_tx_req = 1'b1;
      #1 got = eng_tx_data;
      @(negedge clk);
      eng_tx_req = 1'b0;
      exp = (txq.size() != 0) ? txq.pop_front() : 8'h00;
      if (tx_cnt > 0) tx_cnt--;
      check(got == exp, req, got, exp);
   endtask

   task automatic eng_push(input logic [7:0] b);
      @(negedge clk);
      eng_rx_push = 1'b1; eng_rx_data = b;
      @(negedge clk);
      eng_rx_push = 1'b0;
      if (rx_cnt < DEPTH) begin rxq.push_back(b); rx_cnt++; end
   endtask

   task automatic host_pop(input string req);
      logic [15:0] d;
      logic [7:0]  exp;
      host_read(2'd0, d);
      exp = (rxq.size() != 0) ? rxq.pop_front() : 8'h00;
      if (rx_cnt > 0) rx_cnt--;
      check(d == {8'h00, exp}, req, d, exp);
   endtask

   task automatic set_rem(input int n);
      @(negedge clk);
      eng_rem = 16'(n);
      #1;
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         bad++; total++;
         $display("FAIL watchdog actual=0x0 expected=0x1");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      logic [15:0] d;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // R1 reset state
      host_read(2'd1, d); check(d == 16'h0000, "R1 cfg", d, 0);
      host_read(2'd2, d); check(d == 16'h4000, "R1 R4 status", d, 16'h4000);
      check({tx_ready, rx_ready, tx_drain, rx_drain, rx_overrun, tx_underflow} == 6'b0,
            "R1 events", {tx_ready, rx_ready, tx_drain, rx_drain}, 0);

      // R2 config layout: tx thr 8, rx thr 4, both DMA enables, clear bits set
      host_write(2'd1, 16'hC3C7);
      host_read(2'd1, d); check(d == 16'h8387, "R2 cfg readback", d, 16'h8387);

      // R7 / R9 transmit thresholds
      set_rem(20);
      check(tx_ready == 1'b1, "R7 ready empty", tx_ready, 1);
      for (int i = 0; i < 10; i++) tx_write(8'h10 + 8'(i));
      host_read(2'd2, d); check(d == 16'h400A, "R4 tx level", d, 16'h400A);
      check(tx_ready == 1'b0, "R7 not ready low free", tx_ready, 0);
      set_rem(13);
      check(tx_drain == 1'b1 && tx_ready == 1'b0, "R9 drain short", tx_drain, 1);
      set_rem(10);
      check(tx_drain == 1'b0, "R9 drain none owed", tx_drain, 0);
      set_rem(0);

      // R5 transmit order
      for (int i = 0; i < 10; i++) eng_pull("R5 tx order");

      // R11 underflow
      eng_pull("R11 data zero");
      check(tx_underflow == 1'b1, "R11 pulse", tx_underflow, 1);
      @(negedge clk);
      check(tx_underflow == 1'b0, "R11 one cycle", tx_underflow, 0);

      // R12 write into full transmit queue dropped
      for (int i = 0; i < DEPTH + 1; i++) tx_write(8'h40 + 8'(i));
      host_read(2'd2, d); check(d[6:0] == 7'(DEPTH), "R12 level held", d[6:0], DEPTH);
      for (int i = 0; i < DEPTH; i++) eng_pull("R12 contents");
      host_read(2'd2, d); check(d[6:0] == 7'd0, "R12 drained", d[6:0], 0);

      // R6 / R8 receive thresholds
      set_rem(5);
      for (int i = 0; i < 3; i++) eng_push(8'hA0 + 8'(i));
      check(rx_ready == 1'b0 && rx_drain == 1'b0, "R8 no drain mid-transfer",
            {rx_ready, rx_drain}, 0);
      set_rem(0);
      check(rx_drain == 1'b1, "R8 drain at end", rx_drain, 1);
      eng_push(8'hA3);
      check(rx_ready == 1'b1 && rx_drain == 1'b0, "R6 ready at threshold",
            {rx_ready, rx_drain}, 2);
      host_read(2'd2, d); check(d == 16'h4200, "R4 rx level", d, 16'h4200);
      for (int i = 0; i < 4; i++) host_pop("R5 rx order");

      // R10 read of empty receive queue
      host_pop("R10 empty read zero");
      check(rx_overrun == 1'b1, "R10 pulse empty read", rx_overrun, 1);

      // R10 push into full receive queue
      for (int i = 0; i < DEPTH; i++) eng_push(8'h60 + 8'(i));
      check(rx_overrun == 1'b0, "R10 no pulse below full", rx_overrun, 0);
      eng_push(8'hEE);
      check(rx_overrun == 1'b1, "R10 pulse full push", rx_overrun, 1);
      host_read(2'd2, d); check(d[13:7] == 7'(DEPTH), "R10 level held", d[13:7], DEPTH);

      // R3 flushes touch only the chosen queue
      tx_write(8'h01); tx_write(8'h02);
      host_write(2'd1, 16'hC387);
      host_read(2'd2, d); check(d == 16'h4002, "R3 rx flush only", d, 16'h4002);
      rxq.delete(); rx_cnt = 0;
      host_read(2'd1, d); check(d == 16'h8387, "R2 clear reads 0", d, 16'h8387);
      host_write(2'd1, 16'h83C7);
      host_read(2'd2, d); check(d == 16'h4000, "R3 tx flush", d, 16'h4000);
      txq.delete(); tx_cnt = 0;

      // R5 wrap-around in both queues
      for (int i = 0; i < 3 * DEPTH; i++) begin
         tx_write(8'(i * 7));
         eng_push(8'(i * 5 + 1));
         if (i % 3 == 2) begin
            eng_pull("R5 tx wrap"); eng_pull("R5 tx wrap");
            host_pop("R5 rx wrap"); host_pop("R5 rx wrap");
         end
         if (tx_cnt >= DEPTH - 2) begin
            while (tx_cnt > 0) eng_pull("R5 tx wrap");
            while (rx_cnt > 0) host_pop("R5 rx wrap");
         end
      end
      while (tx_cnt > 0) eng_pull("R5 tx tail");
      while (rx_cnt > 0) host_pop("R5 rx tail");

      done = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule